// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block is the digital sequencer for a switching regulator's start-up and fault recovery. When enabled it turns the gate drivers on and drives a soft-start reference code that climbs from zero to full scale at a constant average rate over a fixed number of timebase ticks. It then holds full scale while the regulator runs. An external timebase supplies a one-cycle tick, nominally once per microsecond, and every delay in the block is counted in these ticks.

While running, the block watches three comparator flags: overcurrent, under-voltage on the switcher feedback and under-voltage on the linear feedback. An overcurrent flag acts at once. An under-voltage flag counts only after it has stayed high for a set number of consecutive ticks. Any accepted fault turns the gates off, waits for a hiccup interval and then reruns soft-start. Faults are not looked at during soft-start. The number of accepted faults is kept across restarts. The fault that reaches the limit either locks the block off or, when only the switcher-feedback under-voltage caused it, raises a request to go back to input-voltage sensing. Only a low enable or a reset clears the fault count, the lock and the request.

Top module: `softstart_hiccup_ctrl`

## Requirements
- R1: While reset is held, and afterwards while `en` stays low, `ss_code` is 0 and `gate_en`, `locked_off` and `resense_req` are all 0.
- R2: On the first clock edge that samples `en` high from the idle state, `gate_en` goes to 1 with `ss_code` at 0. After k ticks of soft-start, `ss_code` equals floor(k*4095/SS_TICKS) (SS_TICKS defaults to 3500). It reaches 4095 at k = SS_TICKS, and the block enters run on the next edge with `ss_code` held at 4095.
- R3: During soft-start, `ss_code` and the ramp position do not move on clock edges where `tick` is low. The ramp resumes from the same point when ticks return.
- R4: In run, an under-voltage flag (switcher or linear) becomes a fault only after it has been high on UV_HOLD_TICKS (default 30) consecutive ticked edges. A flag applied before an edge E causes the fault on edge E+30, counted with a tick on every edge. A pulse that is one tick shorter has no effect on `gate_en`.
- R5: In run, a high `oc_flag` is a fault on the edge that samples it, and `gate_en` is 0 after that edge.
- R6: After a fault below the retry limit, `gate_en` stays 0 with `ss_code` at 0 for HICCUP_TICKS (default 500) ticks. Soft-start then restarts from code 0 with `gate_en` at 1.
- R7: Fault flags present during soft-start are ignored. They neither stop the ramp nor start the under-voltage persistence count, which begins only at the first run edge.
- R8: Accepted faults accumulate across restarts. The MAX_TRIES-th one (default 4), when it involves overcurrent or linear under-voltage, sets `locked_off` to 1 with `gate_en` 0. This state holds for as long as `en` stays high.
- R9: When the MAX_TRIES-th fault is caused only by switcher under-voltage, `resense_req` goes to 1 and `locked_off` stays 0, with `gate_en` at 0, until `en` falls. If linear under-voltage or overcurrent is accepted on the same edge, the lock wins.
- R10: When `en` is sampled low, the next edge returns the block to idle with all outputs 0 and the fault count cleared, so the next fault after re-enabling gives a hiccup and not a lock.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; low acts as shutdown and clears fault history |
| tick | input | 1 | One-cycle timebase strobe (about 1 us) |
| oc_flag | input | 1 | Overcurrent comparator flag |
| uv_sw_flag | input | 1 | Switcher feedback below 75 % of target |
| uv_lin_flag | input | 1 | Linear feedback below 75 % of target |
| ss_code | output | CODE_W (12) | Soft-start reference code |
| gate_en | output | 1 | Gate drivers allowed to switch |
| locked_off | output | 1 | Latched off after retries are used up |
| resense_req | output | 1 | Request to return to input-voltage sensing |

## Verification
The embedded properties check on every cycle that the ramp never falls and freezes without a tick, and that it lands exactly on full scale when its interval ends. They also check that soft-start cannot be left early whatever the fault flags do, that an overcurrent in run drops the gates on the next edge, that the lock and re-sense states hold while enabled, and that a low enable clears everything one edge later. Only the bench scenarios can show the exact ramp values at chosen tick counts, the 30-tick persistence boundary, the hiccup length, the count carried across several restarts and the choice between lock and re-sense.

// File: rtl/sshc_pkg.sv
package sshc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RAMP,
        PH_RUN,
        PH_HICCUP,
        PH_LOCKED,
        PH_RESENSE
    } phase_e;

endpackage

// File: rtl/sshc_persist.sv
// Consecutive-tick persistence filter for one comparator flag.
module sshc_persist #(
    parameter int HOLD_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic raw,
    output logic qualified
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    typedef logic [CW-1:0] cnt_t;
    localparam cnt_t LIMIT = cnt_t'(HOLD_TICKS);

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear || !raw)
            cnt_d = '0;
        else if (tick && cnt_q != LIMIT)
            cnt_d = cnt_q + cnt_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign qualified = (cnt_q == LIMIT);

    AST_QUAL_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        qualified |-> $past(raw) && !$past(clear)); // R4
    AST_QUAL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qualified) |-> $past(tick)); // R4

endmodule

// File: rtl/sshc_ramp.sv
// Constant-rate soft-start code: code = floor(elapsed * FULL / SS_TICKS),
// kept as quotient plus remainder so no multiplier or divider is needed.
module sshc_ramp #(
    parameter int SS_TICKS = 3500,
    parameter int CODE_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              tick,
    output logic [CODE_W-1:0] code,
    output logic              done
);
    localparam int FULL  = (1 << CODE_W) - 1;
    localparam int EW    = $clog2(SS_TICKS + 1);
    localparam int RW    = $clog2(SS_TICKS) + 1;
    localparam int QUOT  = FULL / SS_TICKS;
    localparam int REMN  = FULL % SS_TICKS;

    localparam logic [CODE_W-1:0] STEP_LO = CODE_W'(QUOT);
    localparam logic [CODE_W-1:0] STEP_HI = CODE_W'(QUOT + 1);
    localparam logic [RW-1:0]     INC_R   = RW'(REMN);
    localparam logic [RW-1:0]     MOD_R   = RW'(SS_TICKS);
    localparam logic [EW-1:0]     END_E   = EW'(SS_TICKS);

    typedef struct packed {
        logic [EW-1:0]     elapsed;
        logic [RW-1:0]     rem;
        logic [CODE_W-1:0] code;
    } ramp_t;

    ramp_t r_d, r_q;
    logic [RW-1:0] sum;

    always_comb begin
        r_d = r_q;
        sum = r_q.rem + INC_R;
        if (clear) begin
            r_d = '0;
        end else if (tick && r_q.elapsed != END_E) begin
            r_d.elapsed = r_q.elapsed + EW'(1);
            if (sum >= MOD_R) begin
                r_d.rem  = sum - MOD_R;
                r_d.code = r_q.code + STEP_HI;
            end else begin
                r_d.rem  = sum;
                r_d.code = r_q.code + STEP_LO;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign code = r_q.code;
    assign done = (r_q.elapsed == END_E);

    AST_RAMP_ENDPOINT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> code == CODE_W'(FULL)); // R2
    AST_RAMP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear) |-> code >= $past(code)); // R2
    AST_RAMP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clear) && !$past(tick)) |-> $stable(code)); // R3

endmodule

// File: rtl/softstart_hiccup_ctrl.sv
module softstart_hiccup_ctrl #(
    parameter int SS_TICKS      = 3500,
    parameter int CODE_W        = 12,
    parameter int UV_HOLD_TICKS = 30,
    parameter int HICCUP_TICKS  = 500,
    parameter int MAX_TRIES     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              oc_flag,
    input  logic              uv_sw_flag,
    input  logic              uv_lin_flag,
    output logic [CODE_W-1:0] ss_code,
    output logic              gate_en,
    output logic              locked_off,
    output logic              resense_req
);
    import sshc_pkg::*;

    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam int HW = $clog2(HICCUP_TICKS + 1);
    localparam int NUV = 2; // index 0: switcher, 1: linear

    localparam logic [TW-1:0]     TRY_LIMIT = TW'(MAX_TRIES);
    localparam logic [HW-1:0]     HIC_LAST  = HW'(HICCUP_TICKS - 1);
    localparam logic [CODE_W-1:0] CODE_FULL = '1;

    typedef struct packed {
        phase_e        ph;
        logic [TW-1:0] tries;
        logic [HW-1:0] tmr;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [NUV-1:0]    uv_raw, uv_ok;
    logic [CODE_W-1:0] ramp_code;
    logic              ramp_done;
    logic              fault;
    logic [TW-1:0]     tries_inc;

    assign uv_raw = {uv_lin_flag, uv_sw_flag};

    for (genvar gi = 0; gi < NUV; gi++) begin : g_uv
        sshc_persist #(.HOLD_TICKS(UV_HOLD_TICKS)) u_persist (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (c_q.ph != PH_RUN),
            .tick      (tick),
            .raw       (uv_raw[gi]),
            .qualified (uv_ok[gi])
        );
    end

    sshc_ramp #(.SS_TICKS(SS_TICKS), .CODE_W(CODE_W)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (c_q.ph != PH_RAMP),
        .tick  (tick),
        .code  (ramp_code),
        .done  (ramp_done)
    );

    assign fault     = oc_flag | uv_ok[0] | uv_ok[1];
    assign tries_inc = c_q.tries + TW'(1);

    always_comb begin
        c_d = c_q;
        unique case (c_q.ph)
            PH_IDLE:   if (en) c_d.ph = PH_RAMP;
            PH_RAMP:   if (ramp_done) c_d.ph = PH_RUN;
            PH_RUN: begin
                if (fault) begin
                    c_d.tries = tries_inc;
                    c_d.tmr   = '0;
                    if (tries_inc == TRY_LIMIT)
                        c_d.ph = (oc_flag | uv_ok[1]) ? PH_LOCKED : PH_RESENSE;
                    else
                        c_d.ph = PH_HICCUP;
                end
            end
            PH_HICCUP: begin
                if (tick) begin
                    if (c_q.tmr == HIC_LAST) begin
                        c_d.ph  = PH_RAMP;
                        c_d.tmr = '0;
                    end else begin
                        c_d.tmr = c_q.tmr + HW'(1);
                    end
                end
            end
            default: c_d = c_q;
        endcase
        if (!en) begin
            c_d.ph    = PH_IDLE;
            c_d.tries = '0;
            c_d.tmr   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.ph    <= PH_IDLE;
            c_q.tries <= '0;
            c_q.tmr   <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign ss_code     = (c_q.ph == PH_RUN)  ? CODE_FULL :
                         (c_q.ph == PH_RAMP) ? ramp_code : '0;
    assign gate_en     = (c_q.ph == PH_RAMP) || (c_q.ph == PH_RUN);
    assign locked_off  = (c_q.ph == PH_LOCKED);
    assign resense_req = (c_q.ph == PH_RESENSE);

    AST_EN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!gate_en && !locked_off && !resense_req && ss_code == '0)); // R10
    AST_RAMP_FAULT_BLIND: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ph == PH_RAMP && !ramp_done && en) |=> (c_q.ph == PH_RAMP)); // R7
    AST_OC_CUTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ph == PH_RUN && oc_flag && en) |=> !gate_en); // R5
    AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ph == PH_RAMP && $past(c_q.ph) != PH_RAMP) |-> ss_code == '0); // R6
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_off && en) |=> locked_off); // R8
    AST_RESENSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (resense_req && en) |=> (resense_req && !locked_off)); // R9
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.tries <= TRY_LIMIT); // R8

endmodule

// File: tb/sim_softstart_hiccup_ctrl.sv
`timescale 1ns/1ps
module sim_softstart_hiccup_ctrl;
    localparam int SS  = 3500;
    localparam int UVH = 30;
    localparam int HIC = 500;
    localparam int MXT = 4;
    localparam int B   = 20;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n, en, tick, oc, uvs, uvl;
    logic [11:0] code;
    logic gate, lock, rs;

    always #4 clk = ~clk;

    softstart_hiccup_ctrl #(
        .SS_TICKS(SS), .CODE_W(12), .UV_HOLD_TICKS(UVH),
        .HICCUP_TICKS(HIC), .MAX_TRIES(MXT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .oc_flag(oc), .uv_sw_flag(uvs), .uv_lin_flag(uvl),
        .ss_code(code), .gate_en(gate), .locked_off(lock), .resense_req(rs)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          at;
        logic [11:0] code;
        logic        gate;
        logic        lock;
        logic        rs;
        string       req;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    function automatic logic [11:0] ramp_at(int k);
        longint v;
        v = longint'(k) * 4095 / SS;
        return 12'(v);
    endfunction

    task automatic push(int at, logic [11:0] c, logic g, logic l, logic r, string req);
        exp_t e;
        e.at = at; e.code = c; e.gate = g; e.lock = l; e.rs = r; e.req = req;
        sb.push_back(e);
    endtask

    task automatic at_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // monitor: pops expected items when their cycle comes round
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (e.at != cyc || code !== e.code || gate !== e.gate ||
                lock !== e.lock || rs !== e.rs) begin
                n_bad++;
                $display("FAIL %s at cyc %0d (due %0d): actual code=%0d gate=%0b lock=%0b rs=%0b expected code=%0d gate=%0b lock=%0b rs=%0b",
                         e.req, cyc, e.at, code, gate, lock, rs, e.code, e.gate, e.lock, e.rs);
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual cyc=%0d expected below %0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    // One run-to-fault episode starting from the soft-start entry edge s.
    // kind: 0 hiccup, 1 lock, 2 resense
    task automatic cycle_fault(input int s, input bit f_oc, input bit f_sw, input bit f_lin,
                               input bit shortp, input int kind, input string tag,
                               output int nxt);
        int r, a, f;
        r = s + SS + 1;
        a = r + (shortp ? 50 : 5);
        f = a + (f_oc ? 1 : UVH + 1);
        push(s + 1, ramp_at(1), 1, 0, 0, "R2");
        push(r, 12'hFFF, 1, 0, 0, "R2");
        if (shortp) push(r + 40, 12'hFFF, 1, 0, 0, "R4");
        push(f - 1, 12'hFFF, 1, 0, 0, tag);
        case (kind)
            0: begin
                push(f, 0, 0, 0, 0, tag);
                push(f + HIC - 1, 0, 0, 0, 0, "R6");
                push(f + HIC, 0, 1, 0, 0, "R6");
            end
            1: begin
                push(f, 0, 0, 1, 0, tag);
                push(f + 600, 0, 0, 1, 0, tag);
            end
            default: begin
                push(f, 0, 0, 0, 1, tag);
                push(f + 600, 0, 0, 0, 1, tag);
            end
        endcase
        if (shortp) begin
            at_cyc(r + 5);  uvl = 1;     // 29 ticked edges only
            at_cyc(r + 34); uvl = 0;
        end
        at_cyc(a);
        oc = f_oc; uvs = f_sw; uvl = f_lin;
        at_cyc(f);
        oc = 0; uvs = 0; uvl = 0;
        if (kind == 0) begin
            nxt = f + HIC;
            at_cyc(nxt);
        end else begin
            nxt = f + 601;
            at_cyc(nxt);
        end
    endtask

    task automatic re_enable(output int s);
        int c;
        c = cyc;
        push(c + 1, 0, 0, 0, 0, "R10");
        push(c + 11, 0, 1, 0, 0, "R10");
        en = 0;
        at_cyc(c + 10);
        en = 1;
        s = c + 11;
        at_cyc(s);
    endtask

    initial begin
        int r1, f1, s, rr;
        rst_n = 0; en = 0; tick = 1; oc = 0; uvs = 0; uvl = 0;

        // first soft-start with a 10-tick pause after elapsed 999
        r1 = B + SS + 12;
        f1 = r1 + UVH + 1;
        push(2, 0, 0, 0, 0, "R1");
        push(6, 0, 0, 0, 0, "R1");
        push(B + 1, 0, 1, 0, 0, "R2");
        push(B + 2, ramp_at(1), 1, 0, 0, "R2");
        push(B + 3, ramp_at(2), 1, 0, 0, "R2");
        push(B + 8, ramp_at(7), 1, 0, 0, "R2");
        push(B + 301, ramp_at(300), 1, 0, 0, "R7");
        push(B + 501, ramp_at(500), 1, 0, 0, "R2");
        push(B + 1000, ramp_at(999), 1, 0, 0, "R2");
        push(B + 1005, ramp_at(999), 1, 0, 0, "R3");
        push(B + 1011, ramp_at(1000), 1, 0, 0, "R3");
        push(B + 11 + 1750, ramp_at(1750), 1, 0, 0, "R2");
        push(B + 11 + 3499, ramp_at(3499), 1, 0, 0, "R2");
        push(B + 11 + 3500, 12'hFFF, 1, 0, 0, "R2");
        push(r1, 12'hFFF, 1, 0, 0, "R2");
        push(r1 + 30, 12'hFFF, 1, 0, 0, "R7");
        push(f1, 0, 0, 0, 0, "R4");
        push(f1 + HIC - 1, 0, 0, 0, 0, "R6");
        push(f1 + HIC, 0, 1, 0, 0, "R6");

        at_cyc(3);  rst_n = 1;
        at_cyc(B);  en = 1;
        at_cyc(B + 100); oc = 1; uvs = 1; uvl = 1;   // ignored in soft-start
        at_cyc(B + 300); oc = 0; uvs = 0; uvl = 0;
        at_cyc(B + 1000); tick = 0;
        at_cyc(B + 1010); tick = 1;
        at_cyc(B + 3500); uvs = 1;                    // held across run entry
        at_cyc(f1); uvs = 0;
        at_cyc(f1 + HIC);
        s = f1 + HIC;

        // faults 2..4: overcurrent after a short UV pulse, linear UV, then lock
        cycle_fault(s, 1, 0, 0, 1, 0, "R5", s);
        cycle_fault(s, 0, 0, 1, 0, 0, "R4", s);
        cycle_fault(s, 1, 0, 0, 0, 1, "R8", rr);

        // enable low clears the count; switcher UV limit leads to resense
        re_enable(s);
        cycle_fault(s, 0, 1, 0, 0, 0, "R10", s);
        cycle_fault(s, 1, 0, 0, 0, 0, "R5", s);
        cycle_fault(s, 1, 0, 0, 0, 0, "R5", s);
        cycle_fault(s, 0, 1, 0, 0, 2, "R9", rr);

        // simultaneous switcher and linear UV at the limit: lock wins
        re_enable(s);
        cycle_fault(s, 1, 0, 0, 0, 0, "R5", s);
        cycle_fault(s, 1, 0, 0, 0, 0, "R5", s);
        cycle_fault(s, 1, 0, 0, 0, 0, "R5", s);
        cycle_fault(s, 0, 1, 1, 0, 1, "R9", rr);

        at_cyc(rr + 5);
        if (sb.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 scoreboard not drained: actual %0d left expected 0", sb.size());
        end
        finished = 1;
        summary();
        $finish;
    end
endmodule